// File: doc/BRIEF.md
# Tile Pattern Pixel Decoder

This block converts one tilemap entry and a pixel position inside an 8x8 tile into a 15-bit palette index. Each request carries a 32-bit word that holds two packed 16-bit entries, a flag that picks one of the two, a colour-depth flag, and the pixel's row and column inside the tile. From the chosen entry and the position, the block computes the byte address of the 32-bit pattern word in a 1 MB tile memory. It reads that word through a synchronous port with one cycle of latency, takes the pixel's field from the returned data, and joins that field to upper bits taken from the entry to form the palette index.

Two depths are supported, and every request picks its own. In 4-bit mode a tile has one memory word per row. Bit 15 of the entry becomes the lowest bit of the pattern number, and entry bits also supply the upper part of the palette index. In 8-bit mode a tile has two words per row, and each word holds four pixels. The pipeline takes one request per clock.

Top module: `tile_pix_decoder`

## Requirements
- R1: While reset is high, and in the cycle after it is released, mem_rd_en and out_valid are 0 and out_index is 0.
- R2: req_right = 0 selects req_pair[31:16] as the entry (the even, left tile). req_right = 1 selects req_pair[15:0].
- R3: With req_depth4 = 1 the entry is j=e[15], k=e[14], p=e[13:4], i=e[3:0]. The pattern number is {p, i, j}, and mem_addr = pattern*32 + row*4.
- R4: With req_depth4 = 0 the pattern number is e[14:0] and mem_addr = (pattern*64 + word*4) mod 2^20. Bit 15 of the entry has no effect on the address or on the index.
- R5: In 4-bit mode the pixel at column c is the nibble at bits [31-4c : 28-4c] of the read word. Column 0 is the leftmost pixel.
- R6: In 8-bit mode the word for a pixel is row*2 + col[2], and its pixel is the byte at bits [31-8l : 24-8l] with l = col[1:0].
- R7: In 4-bit mode out_index = {k, p, pixel nibble}.
- R8: In 8-bit mode out_index = {e[14:8], pixel byte}.
- R9: A request sampled at a rising edge drives mem_rd_en high for the following cycle. out_valid is high exactly two cycles after that mem_rd_en cycle. No read and no output appears without a request. Back-to-back requests are accepted every cycle.
- R10: The depth is chosen per request by req_depth4 (1 = 4-bit, 0 = 8-bit). Consecutive requests of different depth decode independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_pair | input | 32 | Word holding two packed tilemap entries |
| req_right | input | 1 | 0 picks the upper entry, 1 the lower |
| req_depth4 | input | 1 | 1 = 4-bit colour, 0 = 8-bit colour |
| req_row | input | 3 | Pixel row inside the tile |
| req_col | input | 3 | Pixel column inside the tile |
| mem_rd_en | output | 1 | Read strobe to tile memory |
| mem_addr | output | 20 | Byte address of the pattern word |
| mem_rd_data | input | 32 | Read data, valid one cycle after the strobe |
| out_valid | output | 1 | Palette index valid |
| out_index | output | 15 | Palette index |

## Verification
The hardest case to reach from the ports is a depth switch between adjacent requests while the pipeline is full. The fields of two different modes are then in flight at once, one in the address stage and one in the pixel stage. The stimulus sweeps every combination of depth, half, row and column over several entry words, with the depth as the fastest-changing variable. Short idle gaps are also mixed in, so that a mode change happens both back-to-back and across bubbles. The bench memory returns a computed function of the address, so a wrong address also produces a wrong index.

// File: rtl/tpd_pkg.sv
package tpd_pkg;
  localparam int ENTRY_W = 16;
  localparam int DATA_W  = 32;
  localparam int IDX_W   = 15;
  localparam int POS_W   = 3;
  localparam int HI_W    = 11;

  typedef enum logic {
    DEPTH_8 = 1'b0,
    DEPTH_4 = 1'b1
  } depth_e;

  typedef struct packed {
    logic              valid;
    logic [2*ENTRY_W-1:0] pair;
    logic              right;
    depth_e            depth;
    logic [POS_W-1:0]  row;
    logic [POS_W-1:0]  col;
  } stage_req_t;

  typedef struct packed {
    logic             valid;
    depth_e           depth;
    logic [POS_W-1:0] col;
    logic [HI_W-1:0]  pal_hi;
  } stage_pix_t;
endpackage

// File: rtl/tpd_entry_sel.sv
module tpd_entry_sel #(
  parameter int ENTRY_W = 16
) (
  input  logic [2*ENTRY_W-1:0] pair,
  input  logic                 right,
  output logic [ENTRY_W-1:0]   entry
);
  always_comb begin
    if (right) entry = pair[ENTRY_W-1:0];
    else       entry = pair[2*ENTRY_W-1:ENTRY_W];
  end
endmodule

// File: rtl/tpd_addr_gen.sv
module tpd_addr_gen
  import tpd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [ENTRY_W-1:0] entry,
  input  depth_e             depth,
  input  logic [POS_W-1:0]   row,
  input  logic [POS_W-1:0]   col,
  output logic [ADDR_W-1:0]  addr,
  output logic [HI_W-1:0]    pal_hi
);
  localparam int FULL_W = ENTRY_W + POS_W + 3;

  logic [FULL_W-1:0] addr4;
  logic [FULL_W-1:0] addr8;

  always_comb begin
    addr4 = {1'b0, 1'b0, entry[13:4], entry[3:0], entry[15], row, 2'b00};
    addr8 = {entry[14:0], row, col[POS_W-1], 2'b00};
    if (depth == DEPTH_4) begin
      addr   = addr4[ADDR_W-1:0];
      pal_hi = {entry[14], entry[13:4]};
    end else begin
      addr   = addr8[ADDR_W-1:0];
      pal_hi = {4'b0000, entry[14:8]};
    end
  end
endmodule

// File: rtl/tpd_pixel_pick.sv
module tpd_pixel_pick
  import tpd_pkg::*;
(
  input  logic [DATA_W-1:0] word,
  input  depth_e            depth,
  input  logic [POS_W-1:0]  col,
  input  logic [HI_W-1:0]   pal_hi,
  output logic [IDX_W-1:0]  index
);
  localparam int NIB_CNT  = DATA_W / 4;
  localparam int BYTE_CNT = DATA_W / 8;

  logic [3:0] nib  [NIB_CNT];
  logic [7:0] lane [BYTE_CNT];

  genvar g;
  generate
    for (g = 0; g < NIB_CNT; g++) begin : g_nib
      assign nib[g] = word[DATA_W-1-4*g -: 4];
    end
    for (g = 0; g < BYTE_CNT; g++) begin : g_lane
      assign lane[g] = word[DATA_W-1-8*g -: 8];
    end
  endgenerate

  always_comb begin
    if (depth == DEPTH_4) index = {pal_hi, nib[col]};
    else                  index = {pal_hi[6:0], lane[col[1:0]]};
  end
endmodule

// File: rtl/tile_pix_decoder.sv
module tile_pix_decoder
  import tpd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [2*ENTRY_W-1:0] req_pair,
  input  logic                 req_right,
  input  logic                 req_depth4,
  input  logic [POS_W-1:0]     req_row,
  input  logic [POS_W-1:0]     req_col,
  output logic                 mem_rd_en,
  output logic [ADDR_W-1:0]    mem_addr,
  input  logic [DATA_W-1:0]    mem_rd_data,
  output logic                 out_valid,
  output logic [IDX_W-1:0]     out_index
);
  stage_req_t s1;
  stage_pix_t s2;

  logic [ENTRY_W-1:0] entry;
  logic [HI_W-1:0]    pal_hi;
  logic [IDX_W-1:0]   index_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
    end else begin
      s1.valid <= req_valid;
      s1.pair  <= req_pair;
      s1.right <= req_right;
      s1.depth <= depth_e'(req_depth4);
      s1.row   <= req_row;
      s1.col   <= req_col;
    end
  end

  tpd_entry_sel #(.ENTRY_W(ENTRY_W)) u_sel (
    .pair  (s1.pair),
    .right (s1.right),
    .entry (entry)
  );

  tpd_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .entry  (entry),
    .depth  (s1.depth),
    .row    (s1.row),
    .col    (s1.col),
    .addr   (mem_addr),
    .pal_hi (pal_hi)
  );

  assign mem_rd_en = s1.valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2 <= '0;
    end else begin
      s2.valid  <= s1.valid;
      s2.depth  <= s1.depth;
      s2.col    <= s1.col;
      s2.pal_hi <= pal_hi;
    end
  end

  tpd_pixel_pick u_pick (
    .word   (mem_rd_data),
    .depth  (s2.depth),
    .col    (s2.col),
    .pal_hi (s2.pal_hi),
    .index  (index_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_index <= '0;
    end else begin
      out_valid <= s2.valid;
      if (s2.valid) out_index <= index_c;
    end
  end
endmodule

// File: rtl/tpd_checker.sv
module tpd_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_depth4,
  input logic [2:0]        req_row,
  input logic [2:0]        req_col,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              out_valid
);
  assert_rd_follows_req_R9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> mem_rd_en);
  assert_no_spurious_rd_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !mem_rd_en);
  assert_out_after_rd_R9: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> ##1 out_valid);
  assert_out_has_rd_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(mem_rd_en, 2));
  assert_word_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> mem_addr[1:0] == 2'b00);
  assert_row_word_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_depth4) |=> mem_addr[4:2] == $past(req_row));
  assert_half_row_word_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_depth4) |=> (mem_addr[2] == $past(req_col[2]))
                                   && (mem_addr[5:3] == $past(req_row)));
endmodule

bind tile_pix_decoder tpd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_depth4 (req_depth4),
  .req_row    (req_row),
  .req_col    (req_col),
  .mem_rd_en  (mem_rd_en),
  .mem_addr   (mem_addr),
  .out_valid  (out_valid)
);

// File: tb/sim_tile_pix_decoder.sv
module sim_tile_pix_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_pair = '0;
  logic        req_right = 1'b0;
  logic        req_depth4 = 1'b0;
  logic [2:0]  req_row = '0;
  logic [2:0]  req_col = '0;
  logic        mem_rd_en;
  logic [19:0] mem_addr;
  logic [31:0] mem_rd_data = '0;
  logic        out_valid;
  logic [14:0] out_index;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  localparam int QD = 4096;
  int          e_addr [QD];
  int          e_idx  [QD];
  int          e_cyc  [QD];
  bit          e_d4   [QD];
  int          wptr = 0;
  int          aptr = 0;
  int          optr = 0;

  tile_pix_decoder u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_pair(req_pair),
    .req_right(req_right), .req_depth4(req_depth4), .req_row(req_row),
    .req_col(req_col), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rd_data(mem_rd_data), .out_valid(out_valid), .out_index(out_index)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] memfn(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ (a << 11) ^ 32'h5A5A0F0F;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= memfn({12'd0, mem_addr});

  task automatic check(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // monitor: compare at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rd_en) begin
        if (aptr >= wptr) check(0, "R9 read without request", 1, 0);
        else begin
          check(cyc == e_cyc[aptr] + 1, "R9 read timing", cyc, e_cyc[aptr] + 1);
          check(int'(mem_addr) == e_addr[aptr],
                e_d4[aptr] ? "R3 R2 R10 address 4-bit" : "R4 R6 R2 R10 address 8-bit",
                int'(mem_addr), e_addr[aptr]);
          aptr++;
        end
      end
      if (out_valid) begin
        if (optr >= wptr) check(0, "R9 output without request", 1, 0);
        else begin
          check(cyc == e_cyc[optr] + 3, "R9 output timing", cyc, e_cyc[optr] + 3);
          check(int'(out_index) == e_idx[optr],
                e_d4[optr] ? "R5 R7 index 4-bit" : "R6 R8 index 8-bit",
                int'(out_index), e_idx[optr]);
          optr++;
        end
      end
    end
  end

  task automatic issue(input logic [31:0] pair, input bit right, input bit d4,
                       input int row, input int col);
    int e, p, i, j, k, pat, addr, idx;
    logic [31:0] data;
    @(negedge clk);
    e = right ? int'(pair[15:0]) : int'(pair[31:16]);
    if (d4) begin
      j = (e >> 15) & 1; k = (e >> 14) & 1; p = (e >> 4) & 1023; i = e & 15;
      pat  = p * 32 + i * 2 + j;
      addr = (pat * 32 + row * 4) % 1048576;
      data = memfn(addr);
      idx  = k * 16384 + p * 16 + int'((data >> (28 - 4 * col)) & 32'hF);
    end else begin
      pat  = e % 32768;
      addr = (pat * 64 + (row * 2 + col / 4) * 4) % 1048576;
      data = memfn(addr);
      idx  = ((e >> 8) & 127) * 256 + int'((data >> (24 - 8 * (col % 4))) & 32'hFF);
    end
    e_addr[wptr] = addr; e_idx[wptr] = idx; e_cyc[wptr] = cyc; e_d4[wptr] = d4;
    wptr++;
    req_valid = 1'b1; req_pair = pair; req_right = right; req_depth4 = d4;
    req_row = 3'(row); req_col = 3'(col);
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      req_valid = 1'b0;
      req_pair = $urandom;
    end
  endtask

  function automatic logic [31:0] pattern(input int n);
    case (n)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_7FFF;
      3: return 32'h7FFF_8000;
      4: return 32'h4001_C00E;
      default: return 32'h1357_9BDF ^ (n * 32'h2468_ACE1);
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, including a request presented under reset
    check(mem_rd_en == 1'b0, "R1 mem_rd_en in reset", int'(mem_rd_en), 0);
    check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    check(out_index == '0,   "R1 out_index in reset", int'(out_index), 0);
    req_valid = 1'b1;
    @(negedge clk);
    check(mem_rd_en == 1'b0, "R1 request ignored in reset", int'(mem_rd_en), 0);
    req_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check(mem_rd_en == 1'b0 && out_valid == 1'b0, "R1 after release",
          int'({mem_rd_en, out_valid}), 0);
    // R2 R10 sweep: depth fastest, then half, column, row, entry word
    for (int n = 0; n < 8; n++) begin
      for (int r = 0; r < 8; r++)
        for (int c = 0; c < 8; c++)
          for (int h = 0; h < 2; h++)
            for (int d = 0; d < 2; d++) begin
              issue(pattern(n), h[0], d[0], r, c);
              if (((n * 64 + r * 8 + c) % 7 == 3) && h == 1 && d == 0) idle(1 + (c % 3));
            end
    end
    idle(6);
    check(aptr == wptr, "R9 all reads seen", aptr, wptr);
    check(optr == wptr, "R9 all outputs seen", optr, wptr);
    done = 1;
    finish_run();
  end

  initial begin
    wait (cyc > 100000);
    if (!done) begin
      check(0, "R9 watchdog expired", cyc, 0);
      finish_run();
    end
  end
endmodule